// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block drives a parallel NOR flash that uses the standard unlock-cycle command set. When it receives a request it carries out one of two operations through a simple bus-master port. It can erase the block at a given address, or it can program one byte at a given address. First it writes the unlock and command cycles. It then polls the device's status reads until the operation completes, fails inside the device, or takes longer than a cycle budget the caller supplies.

For an erase, completion is found by comparing bit 6 across two reads taken back to back. For a program, completion is found by comparing bit 7 of a read with bit 7 of the byte that was written. In both cases, when bit 5 of a read is set, the block makes one final confirmation before it declares a device-side failure. When an operation succeeds, the block writes the read-mode command before it reports done. When an operation fails, it reports at once.

Top module: `nor_cmd_seq`

## Requirements
- R1: An erase writes, in order: 0xF0 to command offset 0x000, 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555 and 0x55 to 0x2AA. It then writes 0x30 to `tgt_addr`.
- R2: A program writes, in order: 0xF0 to command offset 0x000, 0xAA to 0x555, 0x55 to 0x2AA and 0xA0 to 0x555. It then writes `prog_data` to `tgt_addr`.
- R3: When `x16_mode` is 1, every command offset appears on `bus_addr` shifted left by one bit. The write of the data byte and the write of the erase confirm always use `tgt_addr` unchanged.
- R4: Erase polling reads `tgt_addr` twice. If bit 6 is equal in the two reads, the erase has succeeded.
- R5: Suppose bit 6 differs between the two erase reads and bit 5 of the second read is 1. The block then reads `tgt_addr` twice more. If bit 6 still differs, `result` is 1 (device failure). Otherwise `result` is 0 (success).
- R6: Program polling reads `tgt_addr` once. If bit 7 of that read equals bit 7 of `prog_data`, the program has succeeded.
- R7: Suppose bit 7 of a program read does not match and bit 5 of that read is 1. The block then reads once more. A match gives `result` 0. A mismatch gives `result` 1.
- R8: A cycle counter is cleared when the last command write is acknowledged and counts while polling. Suppose a poll round ends with no completion and bit 5 is clear. If the count then exceeds the limit that was latched at the request (`erase_limit` for an erase, `write_limit` for a program), the operation ends with `result` 2 (timeout). `result` never takes the value 3.
- R9: After a success, and before `done`, the block writes 0xF0 to address 0. After a failure or a timeout, `done` follows with no further write.
- R10: `busy` rises on the cycle after an accepted `start` and stays high up to and including the one-cycle `done` pulse. While `busy` is high, `start` is ignored and the operation already running is not changed. `bus_req` is low while the block is idle.
- R11: A bus access is held with `bus_req` high, and `bus_we`, `bus_addr` and `bus_wdata` stable, until `bus_ack` is sampled high. Read data is taken from `bus_rdata` in the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| op_prog | input | 1 | 1 = program one byte, 0 = erase block |
| x16_mode | input | 1 | Shift command offsets left by one |
| tgt_addr | input | AW | Block address or byte address |
| prog_data | input | 8 | Byte to program |
| erase_limit | input | TW | Polling cycle budget for erase |
| write_limit | input | TW | Polling cycle budget for program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 device failure, 2 timeout |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access completion |
| bus_rdata | input | 8 | Read data, valid with bus_ack |

## Verification
The assertions assume that the bus slave acknowledges each request only while that request is pending, and that it never asserts `bus_ack` when `bus_req` is low. The bench flash model respects this. It raises `bus_ack` for exactly one cycle after it sees a request that has not yet been acknowledged, and at the same edge it logs the write or loads the read data. The assertions also assume that `start` is driven only on a clock boundary. The bench therefore changes every input on the falling edge. Where it issues a `start` while the block is busy, it does so only on purpose, to test that the request is ignored.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_RD_A,
        SQ_RD_B,
        SQ_CHK_A,
        SQ_CHK_B,
        SQ_FIN,
        SQ_END
    } sq_state_t;

    typedef enum logic [1:0] {
        RS_OK   = 2'd0,
        RS_HW   = 2'd1,
        RS_SW   = 2'd2
    } sq_result_t;

    localparam int ERASE_WRITES = 7;
    localparam int PROG_WRITES  = 5;
    localparam logic [7:0] CMD_READ_MODE = 8'hF0;

endpackage

// File: rtl/nor_cmd_table.sv
module nor_cmd_table #(
    parameter int AW = 24
) (
    input  logic          is_prog,
    input  logic [2:0]    step,
    input  logic          x16,
    input  logic [AW-1:0] tgt,
    input  logic [7:0]    pdata,
    output logic [AW-1:0] c_addr,
    output logic [7:0]    c_data,
    output logic          c_last
);
    localparam int OFFW = 12;

    logic [OFFW-1:0] off;
    logic            direct;

    always_comb begin
        off    = '0;
        c_data = 8'hF0;
        direct = 1'b0;
        case (step)
            3'd0: begin off = 12'h000; c_data = 8'hF0; end
            3'd1: begin off = 12'h555; c_data = 8'hAA; end
            3'd2: begin off = 12'h2AA; c_data = 8'h55; end
            3'd3: begin off = 12'h555; c_data = is_prog ? 8'hA0 : 8'h80; end
            3'd4: begin
                if (is_prog) begin direct = 1'b1; c_data = pdata; end
                else begin off = 12'h555; c_data = 8'hAA; end
            end
            3'd5: begin off = 12'h2AA; c_data = 8'h55; end
            default: begin direct = 1'b1; c_data = 8'h30; end
        endcase
        if (direct)
            c_addr = tgt;
        else if (x16)
            c_addr = {{(AW-OFFW-1){1'b0}}, off, 1'b0};
        else
            c_addr = {{(AW-OFFW){1'b0}}, off};
        c_last = is_prog ? (step == 3'(nor_seq_pkg::PROG_WRITES - 1))
                         : (step == 3'(nor_seq_pkg::ERASE_WRITES - 1));
    end
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (en && !cnt_q[TW])
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = cnt_q > {1'b0, limit};
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int AW = 24,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_prog,
    input  logic          x16_mode,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    prog_data,
    input  logic [TW-1:0] erase_limit,
    input  logic [TW-1:0] write_limit,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic          bus_ack,
    input  logic [7:0]    bus_rdata
);
    typedef struct packed {
        sq_state_t   st;
        logic [2:0]  step;
        logic        prog;
        logic        x16;
        logic [AW-1:0] tgt;
        logic [7:0]  dat;
        logic [7:0]  first;
        logic [TW-1:0] lim;
        sq_result_t  res;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic [AW-1:0] c_addr;
    logic [7:0]    c_data;
    logic          c_last;
    logic          tmr_clr, tmr_en, tmr_exp;
    logic          polling;

    nor_cmd_table #(.AW(AW)) u_tab (
        .is_prog (r_q.prog),
        .step    (r_q.step),
        .x16     (r_q.x16),
        .tgt     (r_q.tgt),
        .pdata   (r_q.dat),
        .c_addr  (c_addr),
        .c_data  (c_data),
        .c_last  (c_last)
    );

    assign polling = (r_q.st == SQ_RD_A) || (r_q.st == SQ_RD_B) ||
                     (r_q.st == SQ_CHK_A) || (r_q.st == SQ_CHK_B);
    assign tmr_en  = polling;
    assign tmr_clr = (r_q.st == SQ_CMD) && bus_ack && c_last;

    nor_poll_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .limit   (r_q.lim),
        .expired (tmr_exp)
    );

    always_comb begin
        logic match7;
        logic tog6;
        r_d    = r_q;
        match7 = (bus_rdata[7] == r_q.dat[7]);
        tog6   = (bus_rdata[6] != r_q.first[6]);
        case (r_q.st)
            SQ_IDLE: if (start) begin
                r_d.st   = SQ_CMD;
                r_d.step = '0;
                r_d.prog = op_prog;
                r_d.x16  = x16_mode;
                r_d.tgt  = tgt_addr;
                r_d.dat  = prog_data;
                r_d.lim  = op_prog ? write_limit : erase_limit;
                r_d.res  = RS_OK;
            end
            SQ_CMD: if (bus_ack) begin
                if (c_last) r_d.st = SQ_RD_A;
                else        r_d.step = r_q.step + 3'd1;
            end
            SQ_RD_A: if (bus_ack) begin
                r_d.first = bus_rdata;
                if (!r_q.prog)         r_d.st = SQ_RD_B;
                else if (match7)       r_d.st = SQ_FIN;
                else if (bus_rdata[5]) r_d.st = SQ_CHK_B;
                else if (tmr_exp) begin r_d.st = SQ_END; r_d.res = RS_SW; end
                else                   r_d.st = SQ_RD_A;
            end
            SQ_RD_B: if (bus_ack) begin
                if (!tog6)             r_d.st = SQ_FIN;
                else if (bus_rdata[5]) r_d.st = SQ_CHK_A;
                else if (tmr_exp) begin r_d.st = SQ_END; r_d.res = RS_SW; end
                else                   r_d.st = SQ_RD_A;
            end
            SQ_CHK_A: if (bus_ack) begin
                r_d.first = bus_rdata;
                r_d.st    = SQ_CHK_B;
            end
            SQ_CHK_B: if (bus_ack) begin
                if (r_q.prog ? match7 : !tog6) r_d.st = SQ_FIN;
                else begin r_d.st = SQ_END; r_d.res = RS_HW; end
            end
            SQ_FIN: if (bus_ack) begin
                r_d.st  = SQ_END;
                r_d.res = RS_OK;
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= SQ_IDLE;
            r_q.res  <= RS_OK;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy      = (r_q.st != SQ_IDLE);
        done      = (r_q.st == SQ_END);
        result    = r_q.res;
        bus_req   = busy && !done;
        bus_we    = (r_q.st == SQ_CMD) || (r_q.st == SQ_FIN);
        bus_addr  = (r_q.st == SQ_CMD) ? c_addr :
                    (r_q.st == SQ_FIN) ? '0 : r_q.tgt;
        bus_wdata = (r_q.st == SQ_CMD) ? c_data : CMD_READ_MODE;
    end
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [1:0]    result,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_wdata,
    input logic          bus_ack
);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) &&
                                $stable(bus_wdata) && $stable(bus_we));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    p_busy_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    p_done_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_result_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result != 2'd3);

    p_read_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && result == 2'd0 |->
            $past(bus_req && bus_we && bus_ack && bus_wdata == 8'hF0 && bus_addr == '0));
endmodule

bind nor_cmd_seq nor_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_nor_cmd_seq.sv
module sim_nor_cmd_seq;
    localparam int AW = 24;
    localparam int TW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          start = 0, op_prog = 0, x16_mode = 0;
    logic [AW-1:0] tgt_addr = '0;
    logic [7:0]    prog_data = '0;
    logic [TW-1:0] erase_limit = '0, write_limit = '0;
    logic          busy, done;
    logic [1:0]    result;
    logic          bus_req, bus_we, bus_ack;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata, bus_rdata;

    nor_cmd_seq #(.AW(AW), .TW(TW)) u0 (.*);

    // flash model
    logic          m_clr = 0, m_prog = 0, m_dq5 = 0, m_d7 = 0;
    int            m_t = 0;
    int            rc, wn;
    logic [AW-1:0] wa [0:15];
    logic [7:0]    wd [0:15];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack <= 0; bus_rdata <= 0; rc <= 0; wn <= 0;
        end else if (m_clr) begin
            bus_ack <= 0; rc <= 0; wn <= 0;
        end else begin
            bus_ack <= bus_req && !bus_ack;
            if (bus_req && !bus_ack) begin
                if (bus_we) begin
                    if (wn < 16) begin wa[wn] <= bus_addr; wd[wn] <= bus_wdata; end
                    wn <= wn + 1;
                end else begin
                    logic [7:0] v;
                    v = 8'h00;
                    v[5] = m_dq5;
                    if (m_prog) v[7] = (rc < m_t) ? ~m_d7 : m_d7;
                    else        v[6] = (rc < m_t) ? rc[0] : 1'b0;
                    bus_rdata <= v;
                    rc <= rc + 1;
                end
            end
        end
    end

    int total = 0, bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void exp_wr(input bit prog, input int i, input bit x16,
                                   input logic [AW-1:0] tgt, input logic [7:0] pd,
                                   output logic [AW-1:0] a, output logic [7:0] d);
        int off;
        bit dir;
        dir = 0; off = 0; d = 8'hF0;
        case (i)
            0: begin off = 0;     d = 8'hF0; end
            1: begin off = 'h555; d = 8'hAA; end
            2: begin off = 'h2AA; d = 8'h55; end
            3: begin off = 'h555; d = prog ? 8'hA0 : 8'h80; end
            4: if (prog) begin dir = 1; d = pd; end else begin off = 'h555; d = 8'hAA; end
            5: begin off = 'h2AA; d = 8'h55; end
            default: begin dir = 1; d = 8'h30; end
        endcase
        a = dir ? tgt : AW'(x16 ? off * 2 : off);
    endfunction

    task automatic run(input bit prog, input bit x16, input int t, input bit dq5,
                       input int lim, input logic [AW-1:0] tgt, input logic [7:0] pd,
                       input int exp_res, input string tag);
        int n, cyc;
        bit seq_ok;
        logic [AW-1:0] ea;
        logic [7:0] ed;
        @(negedge clk);
        m_clr = 1; m_prog = prog; m_t = t; m_dq5 = dq5; m_d7 = pd[7];
        @(negedge clk);
        m_clr = 0;
        op_prog = prog; x16_mode = x16; tgt_addr = tgt; prog_data = pd;
        erase_limit = TW'(lim); write_limit = TW'(lim);
        start = 1;
        @(negedge clk);
        start = 0;
        cyc = 0;
        while (!done && cyc < 3000) begin @(negedge clk); cyc++; end
        chk(cyc < 3000, {tag, " done seen R10"}, cyc, 0);
        chk(result == 2'(exp_res), {tag, " result R4 R5 R6 R7 R8"}, result, exp_res);
        @(negedge clk);
        n = (prog ? 5 : 7) + (exp_res == 0 ? 1 : 0);
        seq_ok = (wn == n);
        for (int i = 0; i < n && i < 16; i++) begin
            if (i < n - (exp_res == 0 ? 1 : 0)) exp_wr(prog, i, x16, tgt, pd, ea, ed);
            else begin ea = '0; ed = 8'hF0; end
            if (wa[i] !== ea || wd[i] !== ed) seq_ok = 0;
        end
        chk(seq_ok, {tag, prog ? " write order R2 R3 R9" : " write order R1 R3 R9"}, wn, n);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R10 actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_req, "reset idle R10", {busy, done, bus_req}, 0);
        rst_n = 1;
        @(negedge clk);
        // sweep: op x width x toggle length x bit5
        for (int p = 0; p < 2; p++)
            for (int w = 0; w < 2; w++)
                for (int t = 0; t < 6; t++)
                    for (int f = 0; f < 2; f++) begin
                        int er;
                        er = 0;
                        if (f == 1) begin
                            if (p == 1) er = (t >= 2) ? 1 : 0;   // R7
                            else        er = (t >= 4) ? 1 : 0;   // R5
                        end
                        run(p[0], w[0], t, f[0], 1000, 24'h12_3400 + AW'(t * 16),
                            8'h5A ^ 8'(t * 37 + p * 128), er, "sweep");
                    end
        // R8 software timeout, both operations, both widths
        run(0, 0, 100000, 0, 5, 24'h04_0000, 8'h00, 2, "R8 erase timeout");
        run(1, 1, 100000, 0, 9, 24'h04_0011, 8'h81, 2, "R8 program timeout");
        // R8 with a long but finite busy period under a generous limit
        run(0, 1, 21, 0, 200, 24'h08_0000, 8'h00, 0, "R4 long erase");
        // R10 start ignored while busy
        @(negedge clk);
        m_clr = 1; m_prog = 0; m_t = 5; m_dq5 = 0;
        @(negedge clk);
        m_clr = 0; op_prog = 0; x16_mode = 0; tgt_addr = 24'h00_2000; erase_limit = 1000;
        start = 1;
        @(negedge clk);
        op_prog = 1; x16_mode = 1; tgt_addr = 24'h00_7777; prog_data = 8'h11;
        repeat (4) @(negedge clk);
        chk(busy, "R10 busy held", busy, 1);
        repeat (3) @(negedge clk);
        start = 0;
        while (!done) @(negedge clk);
        chk(result == 2'd0, "R10 ignored start result", result, 0);
        @(negedge clk);
        chk(wn == 8 && wd[3] == 8'h80 && wa[6] == 24'h00_2000 && wa[1] == 24'h555,
            "R10 ignored start writes", wn, 8);
        chk(!busy, "R10 idle after done", busy, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule